// File: doc/BRIEF.md
# Shadow Register Bank Selector

This block decides which bank of general-purpose registers a processor core uses when it has several shadow banks besides the normal one. It holds two set numbers: the bank in use now (current) and the bank to resume on the next exception return (previous). When an exception is entered, the current number moves into the previous slot. A newly chosen number then becomes current. When an exception-return instruction retires, the previous number becomes current again.

The new number comes from one of three sources, chosen by the interrupt mode and the exception kind. In external-controller mode, an interrupt uses the set number that the controller sends with the request. In vectored mode, an interrupt uses the 4-bit field of a mapping register that belongs to the interrupt line. Every other exception uses a software-written default. This includes interrupts in classic mode and all non-interrupt exceptions. Only exceptions that raise the exception level from 0 to 1 switch banks. Software can load the previous number and then execute a return, which dispatches code in a chosen bank.

Top module: `gpr_bank_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, cur_set, prev_set, dflt_set, map_value and ext_status all read 0.
- R2: top_set always reads the parameter TOP_SET, the highest implemented set number (3 by default).
- R3: A switching exception with exc_kind=01 (interrupt) and irq_mode=01 (vectored) on line n makes cur_set equal to map_value[4n+3:4n] on the next cycle, so line 7 uses bits [31:28] and line 0 uses bits [3:0]. A field of 0 selects bank 0.
- R4: A switching interrupt with irq_mode=10 (external controller) makes cur_set equal to ext_set on the next cycle, and ext_status latches that number. ext_status keeps it until the next such interrupt. ext_status reads 0 whenever irq_mode is not 10.
- R5: A switching exception with exc_kind=00 (general), or with exc_kind=01 while irq_mode is 00 or 11 (classic), makes cur_set equal to dflt_set on the next cycle.
- R6: On every switching exception, prev_set takes the value cur_set had before the exception.
- R7: An exception switches banks only if exl_in=0 and exc_kind is 00 or 01. When exl_in=1, or exc_kind=10 (cache error), or exc_kind=11 (debug), cur_set and prev_set do not change.
- R8: When ret_valid is high and no switching exception occurs, cur_set takes prev_set on the next cycle, and prev_set is kept.
- R9: If a switching exception and ret_valid arrive in the same cycle, the exception is applied and the return is ignored.
- R10: A selected set number greater than TOP_SET is replaced by 0. A value written to prev_set that is greater than TOP_SET is stored as 0.
- R11: When csr_wr is high, csr_sel picks the target and the write shows on the outputs one cycle later. csr_sel=00 loads the whole map_value from csr_wdata. csr_sel=01 loads dflt_set from csr_wdata[3:0]. csr_sel=10 loads prev_set from csr_wdata[3:0]. csr_sel=11 writes nothing. A prev_set write in the same cycle as a switching exception is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_valid | input | 1 | Exception entry event this cycle |
| exc_kind | input | 2 | 00 general, 01 interrupt, 10 cache error, 11 debug |
| exl_in | input | 1 | Exception level already set when the event arrives |
| irq_mode | input | 2 | 00 classic, 01 vectored, 10 external controller, 11 classic |
| irq_line | input | LINE_W (3) | Interrupt line number in vectored mode |
| ext_set | input | SET_W (4) | Set number proposed by the external controller |
| ret_valid | input | 1 | Exception-return instruction retires this cycle |
| csr_wr | input | 1 | Control-register write strobe |
| csr_sel | input | 2 | Write target: 00 map, 01 default, 10 previous, 11 none |
| csr_wdata | input | MAP_W (32) | Write data |
| cur_set | output | SET_W (4) | Active bank number |
| prev_set | output | SET_W (4) | Bank restored on return |
| dflt_set | output | SET_W (4) | Software default set |
| map_value | output | MAP_W (32) | Per-line mapping register |
| ext_status | output | SET_W (4) | Last set taken from the external controller, 0 outside that mode |
| top_set | output | SET_W (4) | Highest implemented set number |

## Verification
The bench builds the block with eight interrupt lines, 4-bit set numbers and a highest set of 3. With these values, 12 of the 16 possible field, default, external and previous values are out of range. Random writes and external proposals therefore keep reaching the clamp path and the clip variant of the generate block. The random mix of all four modes, all four exception kinds, a set exception level, and colliding returns and writes reaches every source choice and every priority rule. Directed cases pin the field for line 7, a zero mapping, out-of-range values and return dispatch.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;

   // interrupt mode, as decoded from irq_mode
   typedef enum logic [1:0] {
      IMODE_CLASSIC  = 2'b00,
      IMODE_VECTOR   = 2'b01,
      IMODE_EXTERNAL = 2'b10,
      IMODE_RSVD     = 2'b11
   } imode_e;

   // exception class, as decoded from exc_kind
   typedef enum logic [1:0] {
      EXC_GENERAL   = 2'b00,
      EXC_INTERRUPT = 2'b01,
      EXC_CACHE_ERR = 2'b10,
      EXC_DEBUG     = 2'b11
   } exc_kind_e;

   // control-register write target
   typedef enum logic [1:0] {
      CSR_MAP     = 2'b00,
      CSR_DEFAULT = 2'b01,
      CSR_PREV    = 2'b10,
      CSR_NONE    = 2'b11
   } csr_sel_e;

   // origin of the next set number
   typedef enum logic [1:0] {
      SRC_DEFAULT = 2'b00,
      SRC_MAP     = 2'b01,
      SRC_EXT     = 2'b10
   } src_e;

endpackage

// File: rtl/gpr_bank_clamp.sv
module gpr_bank_clamp #(
   parameter int SET_W   = 4,
   parameter int TOP_SET = 3
) (
   input  logic [SET_W-1:0] raw_set,
   output logic [SET_W-1:0] safe_set
);

   localparam bit FULL_RANGE = (TOP_SET == (1 << SET_W) - 1);

   generate
      if (FULL_RANGE) begin : g_pass
         // every encodable number is implemented
         assign safe_set = raw_set;
      end else begin : g_clip
         localparam logic [SET_W-1:0] TOP_L = SET_W'(TOP_SET);
         assign safe_set = (raw_set > TOP_L) ? '0 : raw_set;
      end
   endgenerate

endmodule

// File: rtl/gpr_bank_csr.sv
module gpr_bank_csr
   import gpr_bank_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   parameter  int SET_W     = 4,
   localparam int MAP_W     = NUM_LINES * SET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_wr,
   input  logic [1:0]       csr_sel,
   input  logic [MAP_W-1:0] csr_wdata,
   output logic [MAP_W-1:0] map_q,
   output logic [SET_W-1:0] dflt_q
);

   csr_sel_e sel;
   logic     map_we;
   logic     dflt_we;

   assign sel     = csr_sel_e'(csr_sel);
   assign map_we  = csr_wr && (sel == CSR_MAP);
   assign dflt_we = csr_wr && (sel == CSR_DEFAULT);

   // one register per interrupt line field
   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_field
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               map_q[g*SET_W +: SET_W] <= '0;
            end else if (map_we) begin
               map_q[g*SET_W +: SET_W] <= csr_wdata[g*SET_W +: SET_W];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dflt_q <= '0;
      end else if (dflt_we) begin
         dflt_q <= csr_wdata[SET_W-1:0];
      end
   end

endmodule

// File: rtl/gpr_bank_pick.sv
module gpr_bank_pick
   import gpr_bank_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   parameter  int SET_W     = 4,
   parameter  int TOP_SET   = 3,
   localparam int LINE_W    = $clog2(NUM_LINES),
   localparam int MAP_W     = NUM_LINES * SET_W
) (
   input  logic              exc_valid,
   input  logic [1:0]        exc_kind,
   input  logic              exl_in,
   input  logic [1:0]        irq_mode,
   input  logic [LINE_W-1:0] irq_line,
   input  logic [SET_W-1:0]  ext_set,
   input  logic [MAP_W-1:0]  map_q,
   input  logic [SET_W-1:0]  dflt_q,
   output logic              take,
   output logic              ext_take,
   output logic [SET_W-1:0]  sel_set
);

   exc_kind_e        kind;
   imode_e           mode;
   src_e             src;
   logic [SET_W-1:0] fields [NUM_LINES];
   logic [SET_W-1:0] line_field;
   logic [SET_W-1:0] raw_set;

   assign kind = exc_kind_e'(exc_kind);
   assign mode = imode_e'(irq_mode);

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_slice
         assign fields[g] = map_q[g*SET_W +: SET_W];
      end
   endgenerate

   assign line_field = fields[irq_line];

   // only interrupts in vectored or external mode leave the default path
   always_comb begin
      src = SRC_DEFAULT;
      if (kind == EXC_INTERRUPT) begin
         unique case (mode)
            IMODE_VECTOR:   src = SRC_MAP;
            IMODE_EXTERNAL: src = SRC_EXT;
            default:        src = SRC_DEFAULT;
         endcase
      end
   end

   always_comb begin
      unique case (src)
         SRC_MAP: raw_set = line_field;
         SRC_EXT: raw_set = ext_set;
         default: raw_set = dflt_q;
      endcase
   end

   gpr_bank_clamp #(
      .SET_W   (SET_W),
      .TOP_SET (TOP_SET)
   ) i_sel_clamp (
      .raw_set  (raw_set),
      .safe_set (sel_set)
   );

   // switching requires the level to rise and a return-address-writing class
   assign take     = exc_valid && !exl_in &&
                     ((kind == EXC_GENERAL) || (kind == EXC_INTERRUPT));
   assign ext_take = take && (src == SRC_EXT);

endmodule

// File: rtl/gpr_bank_state.sv
module gpr_bank_state #(
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             ext_take,
   input  logic             ret_valid,
   input  logic [SET_W-1:0] sel_set,
   input  logic             prev_wr,
   input  logic [SET_W-1:0] prev_wdata,
   output logic [SET_W-1:0] cur_q,
   output logic [SET_W-1:0] prev_q,
   output logic [SET_W-1:0] ext_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else if (take) begin
         // exception wins over a return and over a software write
         prev_q <= cur_q;
         cur_q  <= sel_set;
      end else begin
         if (ret_valid) begin
            cur_q <= prev_q;
         end
         if (prev_wr) begin
            prev_q <= prev_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= '0;
      end else if (ext_take) begin
         ext_q <= sel_set;
      end
   end

endmodule

// File: rtl/gpr_bank_selector.sv
module gpr_bank_selector
   import gpr_bank_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   parameter  int SET_W     = 4,
   parameter  int TOP_SET   = 3,
   localparam int LINE_W    = $clog2(NUM_LINES),
   localparam int MAP_W     = NUM_LINES * SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [1:0]        exc_kind,
   input  logic              exl_in,
   input  logic [1:0]        irq_mode,
   input  logic [LINE_W-1:0] irq_line,
   input  logic [SET_W-1:0]  ext_set,
   input  logic              ret_valid,
   input  logic              csr_wr,
   input  logic [1:0]        csr_sel,
   input  logic [MAP_W-1:0]  csr_wdata,
   output logic [SET_W-1:0]  cur_set,
   output logic [SET_W-1:0]  prev_set,
   output logic [SET_W-1:0]  dflt_set,
   output logic [MAP_W-1:0]  map_value,
   output logic [SET_W-1:0]  ext_status,
   output logic [SET_W-1:0]  top_set
);

   // elaboration-time parameter checks
   generate
      if (SET_W < 1 || SET_W > 8) begin : g_bad_set_w
         initial $fatal(1, "gpr_bank_selector: SET_W must lie in 1..8");
      end
      if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
         initial $fatal(1, "gpr_bank_selector: NUM_LINES must be a power of two >= 2");
      end
      if (TOP_SET < 0 || TOP_SET >= (1 << SET_W)) begin : g_bad_top
         initial $fatal(1, "gpr_bank_selector: TOP_SET does not fit in SET_W bits");
      end
   endgenerate

   logic [MAP_W-1:0] map_q;
   logic [SET_W-1:0] dflt_q;
   logic             take;
   logic             ext_take;
   logic [SET_W-1:0] sel_set;
   logic             prev_wr;
   logic [SET_W-1:0] prev_wdata;
   logic [SET_W-1:0] cur_q;
   logic [SET_W-1:0] prev_q;
   logic [SET_W-1:0] ext_q;

   gpr_bank_csr #(
      .NUM_LINES (NUM_LINES),
      .SET_W     (SET_W)
   ) i_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_wr    (csr_wr),
      .csr_sel   (csr_sel),
      .csr_wdata (csr_wdata),
      .map_q     (map_q),
      .dflt_q    (dflt_q)
   );

   gpr_bank_pick #(
      .NUM_LINES (NUM_LINES),
      .SET_W     (SET_W),
      .TOP_SET   (TOP_SET)
   ) i_pick (
      .exc_valid (exc_valid),
      .exc_kind  (exc_kind),
      .exl_in    (exl_in),
      .irq_mode  (irq_mode),
      .irq_line  (irq_line),
      .ext_set   (ext_set),
      .map_q     (map_q),
      .dflt_q    (dflt_q),
      .take      (take),
      .ext_take  (ext_take),
      .sel_set   (sel_set)
   );

   assign prev_wr = csr_wr && (csr_sel_e'(csr_sel) == CSR_PREV);

   gpr_bank_clamp #(
      .SET_W   (SET_W),
      .TOP_SET (TOP_SET)
   ) i_prev_clamp (
      .raw_set  (csr_wdata[SET_W-1:0]),
      .safe_set (prev_wdata)
   );

   gpr_bank_state #(
      .SET_W (SET_W)
   ) i_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .ext_take   (ext_take),
      .ret_valid  (ret_valid),
      .sel_set    (sel_set),
      .prev_wr    (prev_wr),
      .prev_wdata (prev_wdata),
      .cur_q      (cur_q),
      .prev_q     (prev_q),
      .ext_q      (ext_q)
   );

   assign cur_set    = cur_q;
   assign prev_set   = prev_q;
   assign dflt_set   = dflt_q;
   assign map_value  = map_q;
   assign ext_status = (imode_e'(irq_mode) == IMODE_EXTERNAL) ? ext_q : '0;
   assign top_set    = SET_W'(TOP_SET);

endmodule

// File: rtl/gpr_bank_checker.sv
module gpr_bank_checker #(
   parameter  int NUM_LINES = 8,
   parameter  int SET_W     = 4,
   localparam int LINE_W    = $clog2(NUM_LINES),
   localparam int MAP_W     = NUM_LINES * SET_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_valid,
   input logic [1:0]        exc_kind,
   input logic              exl_in,
   input logic [1:0]        irq_mode,
   input logic [LINE_W-1:0] irq_line,
   input logic [SET_W-1:0]  ext_set,
   input logic              ret_valid,
   input logic              csr_wr,
   input logic [1:0]        csr_sel,
   input logic [MAP_W-1:0]  csr_wdata,
   input logic [SET_W-1:0]  cur_set,
   input logic [SET_W-1:0]  prev_set,
   input logic [SET_W-1:0]  dflt_set,
   input logic [MAP_W-1:0]  map_value,
   input logic [SET_W-1:0]  ext_status,
   input logic [SET_W-1:0]  top_set
);

   logic [SET_W-1:0] fields [NUM_LINES];
   logic [SET_W-1:0] vec_field;
   logic             switching;
   logic             is_irq;
   logic             prev_poke;

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_view
         assign fields[g] = map_value[g*SET_W +: SET_W];
      end
   endgenerate

   assign vec_field = fields[irq_line];
   assign is_irq    = (exc_kind == 2'b01);
   assign switching = exc_valid && !exl_in && ((exc_kind == 2'b00) || is_irq);
   assign prev_poke = csr_wr && (csr_sel == 2'b10);

   assert_vector_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (switching && is_irq && irq_mode == 2'b01 && vec_field <= top_set)
      |=> cur_set == $past(vec_field))
      else $error("vectored interrupt did not select its mapping field");

   assert_ext_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (switching && is_irq && irq_mode == 2'b10 && ext_set <= top_set)
      |=> (cur_set == $past(ext_set)) && (irq_mode != 2'b10 || ext_status == $past(ext_set)))
      else $error("external interrupt did not select the proposed set");

   assert_ext_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode != 2'b10) |-> (ext_status == '0))
      else $error("external status visible outside external mode");

   assert_default_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (switching && (!is_irq || irq_mode == 2'b00 || irq_mode == 2'b11) && dflt_set <= top_set)
      |=> cur_set == $past(dflt_set))
      else $error("default set not used");

   assert_prev_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      switching |=> prev_set == $past(cur_set))
      else $error("previous set did not take the old current set");

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !switching && !ret_valid && !prev_poke)
      |=> $stable(cur_set) && $stable(prev_set))
      else $error("non-switching exception changed the sets");

   assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !switching) |=> cur_set == $past(prev_set))
      else $error("return did not restore the previous set");

   assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (switching && ret_valid) |=> prev_set == $past(cur_set))
      else $error("return took effect over an exception");

   assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_set <= top_set) && (prev_set <= top_set))
      else $error("set number beyond highest implemented set");

   assert_prev_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_poke && !switching && csr_wdata[SET_W-1:0] <= top_set)
      |=> prev_set == $past(csr_wdata[SET_W-1:0]))
      else $error("previous-set write lost");

endmodule

bind gpr_bank_selector gpr_bank_checker #(
   .NUM_LINES (NUM_LINES),
   .SET_W     (SET_W)
) i_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .exc_valid  (exc_valid),
   .exc_kind   (exc_kind),
   .exl_in     (exl_in),
   .irq_mode   (irq_mode),
   .irq_line   (irq_line),
   .ext_set    (ext_set),
   .ret_valid  (ret_valid),
   .csr_wr     (csr_wr),
   .csr_sel    (csr_sel),
   .csr_wdata  (csr_wdata),
   .cur_set    (cur_set),
   .prev_set   (prev_set),
   .dflt_set   (dflt_set),
   .map_value  (map_value),
   .ext_status (ext_status),
   .top_set    (top_set)
);

// File: tb/test_gpr_bank_selector.sv
module test_gpr_bank_selector;

   localparam int CLK_PERIOD = 10;
   localparam int NL         = 8;
   localparam int SW         = 4;
   localparam int TS         = 3;
   localparam int LW         = 3;
   localparam int MW         = NL * SW;
   localparam int RAND_STEPS = 3000;
   localparam int WD_CYCLES  = 50000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          exc_valid;
   logic [1:0]    exc_kind;
   logic          exl_in;
   logic [1:0]    irq_mode;
   logic [LW-1:0] irq_line;
   logic [SW-1:0] ext_set;
   logic          ret_valid;
   logic          csr_wr;
   logic [1:0]    csr_sel;
   logic [MW-1:0] csr_wdata;
   logic [SW-1:0] cur_set;
   logic [SW-1:0] prev_set;
   logic [SW-1:0] dflt_set;
   logic [MW-1:0] map_value;
   logic [SW-1:0] ext_status;
   logic [SW-1:0] top_set;

   int checks   = 0;
   int failures = 0;

   // reference state
   logic [SW-1:0] m_cur;
   logic [SW-1:0] m_prev;
   logic [SW-1:0] m_dflt;
   logic [MW-1:0] m_map;
   logic [SW-1:0] m_ext;
   string         tag_cur;
   string         tag_prev;

   always #(CLK_PERIOD / 2) clk = ~clk;

   gpr_bank_selector #(
      .NUM_LINES (NL),
      .SET_W     (SW),
      .TOP_SET   (TS)
   ) i_gpr_bank_selector (
      .clk        (clk),
      .rst_n      (rst_n),
      .exc_valid  (exc_valid),
      .exc_kind   (exc_kind),
      .exl_in     (exl_in),
      .irq_mode   (irq_mode),
      .irq_line   (irq_line),
      .ext_set    (ext_set),
      .ret_valid  (ret_valid),
      .csr_wr     (csr_wr),
      .csr_sel    (csr_sel),
      .csr_wdata  (csr_wdata),
      .cur_set    (cur_set),
      .prev_set   (prev_set),
      .dflt_set   (dflt_set),
      .map_value  (map_value),
      .ext_status (ext_status),
      .top_set    (top_set)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] clampv(logic [SW-1:0] v);
      return (v > SW'(TS)) ? '0 : v;
   endfunction

   task automatic set_in(logic e, logic [1:0] k, logic x, logic [1:0] md, logic [LW-1:0] ln,
                         logic [SW-1:0] es, logic r, logic w, logic [1:0] s, logic [MW-1:0] d);
      exc_valid = e; exc_kind = k; exl_in = x; irq_mode = md; irq_line = ln;
      ext_set = es; ret_valid = r; csr_wr = w; csr_sel = s; csr_wdata = d;
   endtask

   task automatic go_idle();
      exc_valid = 1'b0; ret_valid = 1'b0; csr_wr = 1'b0;
   endtask

   // next reference state from the inputs now applied (requirements R3..R11)
   task automatic model_step();
      logic [SW-1:0] raw;
      logic [SW-1:0] sel;
      logic          is_irq;
      logic          tk;
      is_irq = (exc_kind == 2'd1);
      tk     = exc_valid && !exl_in && (exc_kind == 2'd0 || is_irq);
      if (is_irq && irq_mode == 2'd1)      raw = m_map[int'(irq_line) * SW +: SW];
      else if (is_irq && irq_mode == 2'd2) raw = ext_set;
      else                                 raw = m_dflt;
      sel = clampv(raw);
      if (tk) begin
         if (sel != raw)                       tag_cur = "R10";
         else if (is_irq && irq_mode == 2'd1)  tag_cur = "R3";
         else if (is_irq && irq_mode == 2'd2)  tag_cur = "R4";
         else                                  tag_cur = "R5";
         if (ret_valid) tag_cur = "R9";
         tag_prev = "R6";
         m_prev = m_cur;
         m_cur  = sel;
         if (is_irq && irq_mode == 2'd2) m_ext = sel;
      end else begin
         tag_cur  = ret_valid ? "R8" : "R7";
         tag_prev = "R7";
         if (ret_valid) m_cur = m_prev;
         if (csr_wr && csr_sel == 2'd2) begin
            m_prev   = clampv(csr_wdata[SW-1:0]);
            tag_prev = "R11";
         end
      end
      if (csr_wr && csr_sel == 2'd0) m_map  = csr_wdata;
      if (csr_wr && csr_sel == 2'd1) m_dflt = csr_wdata[SW-1:0];
   endtask

   task automatic cycle();
      model_step();
      @(negedge clk);
      chk(tag_cur,  "cur_set",    32'(cur_set),  32'(m_cur));
      chk(tag_prev, "prev_set",   32'(prev_set), 32'(m_prev));
      chk("R11",    "dflt_set",   32'(dflt_set), 32'(m_dflt));
      chk("R11",    "map_value",  32'(map_value), 32'(m_map));
      chk("R4",     "ext_status", 32'(ext_status),
          (irq_mode == 2'd2) ? 32'(m_ext) : 32'd0);
      go_idle();
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd7151));
      rst_n = 1'b0;
      set_in(1'b0, 2'd0, 1'b0, 2'd0, '0, '0, 1'b0, 1'b0, 2'd3, '0);
      m_cur = '0; m_prev = '0; m_dflt = '0; m_map = '0; m_ext = '0;
      repeat (3) @(negedge clk);
      // R1 reset state, R2 highest set
      chk("R1", "cur_set in reset",   32'(cur_set),   32'd0);
      chk("R1", "prev_set in reset",  32'(prev_set),  32'd0);
      chk("R1", "dflt_set in reset",  32'(dflt_set),  32'd0);
      chk("R1", "map_value in reset", 32'(map_value), 32'd0);
      chk("R1", "ext_status in reset", 32'(ext_status), 32'd0);
      chk("R2", "top_set", 32'(top_set), 32'(TS));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cur_set after reset",  32'(cur_set),  32'd0);
      chk("R1", "prev_set after reset", 32'(prev_set), 32'd0);

      // R11 map write: line 7 -> 3, line 1 -> 0, line 0 -> 2
      set_in(1'b0, 2'd0, 1'b0, 2'd1, '0, '0, 1'b0, 1'b1, 2'd0, 32'h3000_0002); cycle();
      // R3 vectored line 7 uses bits [31:28]
      set_in(1'b1, 2'd1, 1'b0, 2'd1, 3'd7, '0, 1'b0, 1'b0, 2'd3, '0); cycle();
      chk("R3", "line 7 field", 32'(cur_set), 32'd3);
      // R8 return restores bank 0
      set_in(1'b0, 2'd0, 1'b0, 2'd1, '0, '0, 1'b1, 1'b0, 2'd3, '0); cycle();
      // R3 zero field keeps bank 0
      set_in(1'b1, 2'd1, 1'b0, 2'd1, 3'd1, '0, 1'b0, 1'b0, 2'd3, '0); cycle();
      chk("R3", "zero field", 32'(cur_set), 32'd0);
      // R4 external interrupt, then status masked in classic mode
      set_in(1'b1, 2'd1, 1'b0, 2'd2, '0, 4'd2, 1'b0, 1'b0, 2'd3, '0); cycle();
      chk("R4", "ext_status latched", 32'(ext_status), 32'd2);
      irq_mode = 2'd0;
      #1 chk("R4", "ext_status masked", 32'(ext_status), 32'd0);
      // R7 exception with level set, cache error and debug leave sets alone
      set_in(1'b1, 2'd0, 1'b1, 2'd0, '0, '0, 1'b0, 1'b0, 2'd3, '0); cycle();
      set_in(1'b1, 2'd2, 1'b0, 2'd0, '0, '0, 1'b0, 1'b0, 2'd3, '0); cycle();
      set_in(1'b1, 2'd3, 1'b0, 2'd2, '0, 4'd1, 1'b0, 1'b0, 2'd3, '0); cycle();
      // R5 default set 1 on a classic interrupt
      set_in(1'b0, 2'd0, 1'b0, 2'd0, '0, '0, 1'b0, 1'b1, 2'd1, 32'd1); cycle();
      set_in(1'b1, 2'd1, 1'b0, 2'd0, 3'd7, '0, 1'b0, 1'b0, 2'd3, '0); cycle();
      chk("R5", "classic uses default", 32'(cur_set), 32'd1);
      // R9 exception and return together
      set_in(1'b1, 2'd0, 1'b0, 2'd0, '0, '0, 1'b1, 1'b0, 2'd3, '0); cycle();
      // R10 out-of-range proposal and previous write clamp to 0
      set_in(1'b1, 2'd1, 1'b0, 2'd2, '0, 4'd9, 1'b0, 1'b0, 2'd3, '0); cycle();
      chk("R10", "clamped ext proposal", 32'(cur_set), 32'd0);
      set_in(1'b0, 2'd0, 1'b0, 2'd0, '0, '0, 1'b0, 1'b1, 2'd2, 32'd7); cycle();
      chk("R10", "clamped prev write", 32'(prev_set), 32'd0);
      // R11 dispatch: write previous set 2 then return
      set_in(1'b0, 2'd0, 1'b0, 2'd0, '0, '0, 1'b0, 1'b1, 2'd2, 32'd2); cycle();
      set_in(1'b0, 2'd0, 1'b0, 2'd0, '0, '0, 1'b1, 1'b0, 2'd3, '0); cycle();
      chk("R11", "dispatch via return", 32'(cur_set), 32'd2);
      // R11 write collides with a switching exception
      set_in(1'b1, 2'd0, 1'b0, 2'd0, '0, '0, 1'b0, 1'b1, 2'd2, 32'd3); cycle();

      // constrained random mix
      for (int i = 0; i < RAND_STEPS; i++) begin
         logic [MW-1:0] wd;
         logic [1:0]    s;
         s  = 2'($urandom_range(0, 3));
         wd = 32'($urandom_range(0, 15));
         if (s == 2'd0) begin
            for (int k = 0; k < NL; k++) wd[k*SW +: SW] = SW'($urandom_range(0, 5));
         end
         set_in($urandom_range(0, 99) < 40, 2'($urandom_range(0, 3)),
                $urandom_range(0, 99) < 25, 2'($urandom_range(0, 3)),
                LW'($urandom_range(0, NL - 1)), SW'($urandom_range(0, 5)),
                $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 30, s, wd);
         cycle();
      end

      summary();
      $finish;
   end

endmodule